// File: doc/BRIEF.md
# I2C Register Slave with Pair Snapshot

This block is a slave on a two-wire I2C bus that gives a host byte-wide access to a register map of 256 locations. The host first writes a memory-address byte and then reads or writes data bytes. The address moves up by one after each byte. The block owns no storage of its own apart from a one-byte snapshot and a software-reset flag. It presents the map through a simple register port: a read address with two combinational read-data inputs, and a one-cycle write strobe with an address and a data byte.

The bus is sampled against a fast system clock. START, STOP and repeated START are decoded from the sampled edges, and SDA is driven as an open-drain enable. Some measurement values span two bytes. For these, reading the upper byte also captures the lower byte, so a value that changes between the two byte reads is still returned as a consistent pair. Writes pass through an address-class filter. Writes to the command location are accepted only when the host addresses that location directly.

Top module: `i2c_regslave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 011 followed by the four `dev_lo` bits (default 0110, which gives write byte 6Ch and read byte 6Dh). Any other address gets no acknowledge, and the block then ignores every following byte until the next START.
- R2: The last bit of the address byte selects the transfer direction. A 0 means the next byte is a memory address followed by data to write. A 1 means the block drives read data, starting at the current memory address.
- R3: In a write burst the block acknowledges every data byte. It stores each byte at the current memory address and then moves that address up by one.
- R4: A read is set up by writing the memory address, sending a repeated START and then the read address byte. The block returns bytes from consecutive addresses and releases SDA for good once the master answers a byte with NAK.
- R5: Locations 00h, 02h, 04h and 06h are the upper bytes of two-byte values, with the lower byte at the next odd address. Reading an upper byte captures its lower byte, and that captured value is returned for the odd address until the command ends at START or STOP. Reading any other address returns live map data.
- R6: Only addresses 10h to 6Fh and FEh are writable. A write to any other address is dropped, and the map keeps its old value.
- R7: FEh is the command location. A write that reaches FEh by auto-increment is dropped. A write to FEh sent as the first data byte after the memory address is accepted.
- R8: A read whose address moves past FFh returns FFh.
- R9: A data byte cut short by STOP before its eighth bit is not written.
- R10: An accepted write to FEh with bit 0 set raises `srst_o`. The flag falls at the next START or STOP on the bus.
- R11: After reset, SDA is released, no write strobe is active and `srst_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, pull SDA low (open-drain) |
| dev_lo | input | 4 | Configurable lower nibble of the slave address |
| reg_raddr | output | 8 | Map read address (current memory address) |
| reg_rdata | input | 8 | Map byte at `reg_raddr` |
| reg_rdata_odd | input | 8 | Map byte at `reg_raddr` with bit 0 forced to 1 |
| reg_we | output | 1 | One-cycle write strobe to the map |
| reg_waddr | output | 8 | Map write address |
| reg_wdata | output | 8 | Map write data |
| srst_o | output | 1 | Software-reset flag from the command location |

## Verification
A table of single-byte writes, each followed by a read-back, covers writable addresses across the whole writable range as well as read-only, pair and high addresses. This separates address-class filtering from plain storage. Bursts of four bytes written and read back show auto-increment in both directions and that SDA is released after NAK. To test the snapshot, the bench changes the lower byte between the two byte reads, once on a pair address and once on an ordinary one. This separates a true capture from a delayed live read and from capture that is applied too widely. Directed sequences cover address mismatch and a changed address nibble, writes that step into the command location versus direct writes to it, reads past FFh, a byte cut off by STOP, and the flag clearing on both STOP and repeated START.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter logic [2:0]   DEV_HI    = 3'b011,
  parameter logic [7:0]   CMD_ADDR  = 8'hFE,
  parameter int           SRST_BIT  = 0,
  parameter logic [255:0] WR_MASK   = (((256'd1 << 112) - 256'd1) ^ ((256'd1 << 16) - 256'd1)) | (256'd1 << 254),
  parameter logic [255:0] PAIR_MASK = 256'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [3:0] dev_lo,
  output logic [7:0] reg_raddr,
  input  logic [7:0] reg_rdata,
  input  logic [7:0] reg_rdata_odd,
  output logic       reg_we,
  output logic [7:0] reg_waddr,
  output logic [7:0] reg_wdata,
  output logic       srst_o
);
  typedef enum logic [2:0] {S_IDLE, S_DEV, S_MAD, S_WR, S_RD} st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q;
  logic [3:0] bitcnt;
  logic [7:0] sr, tx, snap_lo, wa, wd;
  logic [6:0] snap_idx;
  logic [8:0] maddr;
  logic       in_ack, first_wr, snap_v;

  wire scl_s     = scl_q[1];
  wire sda_s     = sda_q[1];
  wire start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire scl_rise  = scl_s & ~scl_q[2];
  wire scl_fall  = ~scl_s & scl_q[2];
  wire rx_bit    = (st == S_DEV || st == S_MAD || st == S_WR) && !in_ack && bitcnt < 4'd8;

  wire       pair_hit = snap_v && !maddr[8] && maddr[7:0] == {snap_idx, 1'b1};
  wire [7:0] rbyte    = maddr[8] ? 8'hFF : (pair_hit ? snap_lo : reg_rdata);
  wire       wr_ok    = !maddr[8] && WR_MASK[maddr[7:0]] && !(maddr[7:0] == CMD_ADDR && !first_wr);
  wire [8:0] maddr_nx = maddr[8] ? maddr : maddr + 9'd1;

  assign reg_raddr = maddr[7:0];
  assign reg_waddr = wa;
  assign reg_wdata = wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      sr       <= '0;
      tx       <= '0;
      maddr    <= '0;
      in_ack   <= 1'b0;
      first_wr <= 1'b0;
      sda_oe   <= 1'b0;
      snap_v   <= 1'b0;
      snap_idx <= '0;
      snap_lo  <= '0;
      reg_we   <= 1'b0;
      wa       <= '0;
      wd       <= '0;
      srst_o   <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        st     <= S_DEV;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
        snap_v <= 1'b0;
        srst_o <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
        snap_v <= 1'b0;
        srst_o <= 1'b0;
      end else if (scl_rise) begin
        if (rx_bit) begin
          sr     <= {sr[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (st == S_RD && in_ack && sda_s) begin
          st <= S_IDLE;
        end
      end else if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          bitcnt <= '0;
          sda_oe <= 1'b0;
          if (st == S_RD) begin
            tx     <= rbyte;
            sda_oe <= ~rbyte[7];
            bitcnt <= 4'd1;
            if (!maddr[8] && !maddr[0] && PAIR_MASK[maddr[7:0]]) begin
              snap_v   <= 1'b1;
              snap_idx <= maddr[7:1];
              snap_lo  <= reg_rdata_odd;
            end
          end
        end else if (st == S_RD) begin
          if (bitcnt == 4'd8) begin
            sda_oe <= 1'b0;
            in_ack <= 1'b1;
            maddr  <= maddr_nx;
          end else begin
            sda_oe <= ~tx[3'd7 - bitcnt[2:0]];
            bitcnt <= bitcnt + 4'd1;
          end
        end else if (bitcnt == 4'd8) begin
          case (st)
            S_DEV:
              if (sr[7:1] == {DEV_HI, dev_lo}) begin
                in_ack <= 1'b1;
                sda_oe <= 1'b1;
                st     <= sr[0] ? S_RD : S_MAD;
              end else begin
                st <= S_IDLE;
              end
            S_MAD: begin
              in_ack   <= 1'b1;
              sda_oe   <= 1'b1;
              maddr    <= {1'b0, sr};
              first_wr <= 1'b1;
              st       <= S_WR;
            end
            S_WR: begin
              in_ack   <= 1'b1;
              sda_oe   <= 1'b1;
              first_wr <= 1'b0;
              maddr    <= maddr_nx;
              if (wr_ok) begin
                reg_we <= 1'b1;
                wa     <= maddr[7:0];
                wd     <= sr;
                if (maddr[7:0] == CMD_ADDR && sr[SRST_BIT]) srst_o <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  a_r6_write_class: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> WR_MASK[reg_waddr]);

  a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  a_r10_srst_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_o) |-> (reg_we && reg_waddr == CMD_ADDR));

  a_r10_srst_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !srst_o);

  a_r2_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD) |-> !reg_we);
endmodule

// File: tb/i2c_regslave_tb.sv
module i2c_regslave_tb;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] dev_lo = 4'b0110;
  logic       sda_oe, reg_we, srst_o;
  logic [7:0] reg_raddr, reg_rdata, reg_rdata_odd, reg_waddr, reg_wdata;
  logic       poke = 1'b0;
  logic [7:0] poke_a = '0, poke_d = '0;
  logic [7:0] mem [256];
  logic [7:0] em  [256];
  int checks = 0, fails = 0;

  wire sda = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_regslave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda), .sda_oe(sda_oe),
    .dev_lo(dev_lo), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .reg_rdata_odd(reg_rdata_odd), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .srst_o(srst_o)
  );

  assign reg_rdata     = mem[reg_raddr];
  assign reg_rdata_odd = mem[{reg_raddr[7:1], 1'b1}];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (reg_we) begin
      mem[reg_waddr] <= reg_wdata;
    end else if (poke) begin
      mem[poke_a] <= poke_d;
    end
  end

  // {writable, address, data}
  localparam logic [16:0] TV [6] = '{
    {1'b1, 8'h10, 8'h3C}, {1'b1, 8'h55, 8'hC3}, {1'b1, 8'h6F, 8'h81},
    {1'b0, 8'h70, 8'h7E}, {1'b0, 8'h02, 8'h99}, {1'b0, 8'h80, 8'h11}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic do_poke(input logic [7:0] a, input logic [7:0] d);
    poke_a = a; poke_d = d; poke = 1'b1;
    @(posedge clk); #1;
    poke = 1'b0;
    em[a] = d;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); b = sda; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic sendb(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = !b;
  endtask

  task automatic recv8(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d, output logic ack);
    logic k;
    bus_start();
    sendb({3'b011, dev_lo, 1'b0}, k);
    sendb(a, k);
    sendb(d, ack);
    bus_stop();
  endtask

  task automatic rd_open(input logic [7:0] a);
    logic k;
    bus_start();
    sendb({3'b011, dev_lo, 1'b0}, k);
    sendb(a, k);
    bus_start();
    sendb({3'b011, dev_lo, 1'b1}, k);
  endtask

  task automatic rd1(input logic [7:0] a, output logic [7:0] d);
    rd_open(a);
    recv8(d);
    wbit(1'b1);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] d, d0, d1;
    for (int i = 0; i < 256; i++) em[i] = 8'(i) ^ 8'hA5;
    repeat (5) @(posedge clk);
    #1;
    chk("R11 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    hq();
    chk("R11 sda released", sda_oe, 0);
    chk("R11 no write strobe", reg_we, 0);
    chk("R11 srst low", srst_o, 0);

    // Table walk: single writes with read-back (R3, R6)
    for (int v = 0; v < 6; v++) begin
      wr1(TV[v][15:8], TV[v][7:0], ack);
      chk("R3 data byte acked", ack, 1);
      if (TV[v][16]) em[TV[v][15:8]] = TV[v][7:0];
      rd1(TV[v][15:8], d);
      chk(TV[v][16] ? "R3 readback" : "R6 write dropped", d, em[TV[v][15:8]]);
      chk("R6 map content", mem[TV[v][15:8]], em[TV[v][15:8]]);
    end

    // Burst write then burst read (R2, R3, R4)
    bus_start();
    sendb(8'h6C, ack); chk("R1 address acked", ack, 1);
    sendb(8'h20, ack);
    for (int i = 0; i < 4; i++) begin
      sendb(8'h40 + 8'(i * 17), ack);
      em[8'h20 + 8'(i)] = 8'h40 + 8'(i * 17);
    end
    bus_stop();
    rd_open(8'h20);
    for (int i = 0; i < 4; i++) begin
      recv8(d);
      chk(i == 0 ? "R2 read direction data" : "R4 burst read", d, em[8'h20 + 8'(i)]);
      chk("R3 burst write stored", mem[8'h20 + 8'(i)], em[8'h20 + 8'(i)]);
      wbit(i == 3);
    end
    chk("R4 sda released after NAK", sda_oe, 0);
    hq(); hq();
    chk("R4 sda stays released", sda_oe, 0);
    bus_stop();

    // Address mismatch (R1)
    bus_start();
    sendb(8'h6E, ack); chk("R1 mismatch not acked", ack, 0);
    sendb(8'h40, ack); chk("R1 ignored byte not acked", ack, 0);
    sendb(8'hAA, ack);
    bus_stop();
    chk("R1 ignored write", mem[8'h40], em[8'h40]);
    dev_lo = 4'b1001;
    wr1(8'h41, 8'h5D, ack);
    em[8'h41] = 8'h5D;
    chk("R1 new nibble acked", ack, 1);
    chk("R1 new nibble write", mem[8'h41], 8'h5D);
    bus_start();
    sendb(8'h6C, ack); chk("R1 old address refused", ack, 0);
    bus_stop();
    dev_lo = 4'b0110;

    // Snapshot (R5)
    do_poke(8'h04, 8'hB1);
    do_poke(8'h05, 8'hB2);
    rd_open(8'h04);
    recv8(d0);
    do_poke(8'h05, 8'hC7);
    wbit(1'b0);
    recv8(d1);
    wbit(1'b1);
    bus_stop();
    chk("R5 upper byte", d0, 8'hB1);
    chk("R5 lower byte captured", d1, 8'hB2);
    rd1(8'h05, d);
    chk("R5 live after command end", d, 8'hC7);
    do_poke(8'h20, 8'h61);
    do_poke(8'h21, 8'h62);
    rd_open(8'h20);
    recv8(d0);
    do_poke(8'h21, 8'h63);
    wbit(1'b0);
    recv8(d1);
    wbit(1'b1);
    bus_stop();
    chk("R5 non-pair is live", d1, 8'h63);

    // Auto-increment into command location (R7)
    bus_start();
    sendb(8'h6C, ack); sendb(8'hFD, ack);
    sendb(8'h12, ack); sendb(8'h01, ack);
    chk("R7 auto-inc no srst", srst_o, 0);
    bus_stop();
    chk("R7 auto-inc write dropped", mem[8'hFE], em[8'hFE]);
    chk("R6 FDh unchanged", mem[8'hFD], em[8'hFD]);

    // Direct command write and clearing (R7, R10)
    bus_start();
    sendb(8'h6C, ack); sendb(8'hFE, ack); sendb(8'h01, ack);
    em[8'hFE] = 8'h01;
    chk("R10 srst set", srst_o, 1);
    bus_stop();
    chk("R10 srst cleared by STOP", srst_o, 0);
    chk("R7 direct write stored", mem[8'hFE], 8'h01);
    bus_start();
    sendb(8'h6C, ack); sendb(8'hFE, ack); sendb(8'h03, ack);
    em[8'hFE] = 8'h03;
    chk("R10 srst set again", srst_o, 1);
    bus_start();
    chk("R10 srst cleared by START", srst_o, 0);
    bus_stop();

    // Read past FFh (R8)
    do_poke(8'hFF, 8'h5A);
    rd_open(8'hFE);
    recv8(d); wbit(1'b0); chk("R8 FEh", d, em[8'hFE]);
    recv8(d); wbit(1'b0); chk("R8 FFh", d, 8'h5A);
    recv8(d); wbit(1'b1); chk("R8 past end", d, 8'hFF);
    bus_stop();

    // Incomplete byte (R9)
    bus_start();
    sendb(8'h6C, ack); sendb(8'h30, ack); sendb(8'h44, ack);
    em[8'h30] = 8'h44;
    for (int i = 0; i < 4; i++) wbit(1'b1);
    bus_stop();
    chk("R9 full byte written", mem[8'h30], 8'h44);
    chk("R9 partial byte dropped", mem[8'h31], em[8'h31]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule